// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two 16-bit timer/counters. Each is kept as a low byte and a high byte. An 8-bit mode register gives every unit a control nibble. The nibble selects whether the unit advances on internal clock ticks or on falling edges of an external count pin, and whether an external interrupt pin gates it. It also picks one of four counting modes that share the same byte registers: a 13-bit layout, a full 16-bit layout, an 8-bit layout that reloads itself from the high byte, and a split layout. In the split layout, the high byte of timer 0 runs as a third 8-bit timer under timer 1's run input, and timer 1 stops.

Software reaches the mode register, the four count bytes and the two overflow flags through a small single-cycle register bus. Each timer has a run input. Each counter raises a sticky overflow flag when it wraps, and that flag is also driven out on a port.

Top module: `dual_timer_counter`

## Requirements
- R1: The bus uses `addr` 0 for the mode register, 1 and 2 for timer 0's low and high bytes, 3 and 4 for timer 1's low and high bytes, and 5 for the flags (bit 0 for timer 0, bit 1 for timer 1). `rdData` is combinational from `addr`, and addresses 6 and 7 read 0. In the mode register, bits 3:0 control timer 0 and bits 7:4 control timer 1. Within a nibble, bit 3 is the gate enable, bit 2 is the counter select and bits 1:0 are the mode.
- R2: With the gate bit set, a unit advances only in cycles where its run input and its interrupt pin are both high. With the gate bit clear, the run input alone enables it.
- R3: With the counter select clear, a unit advances once per clock. With it set, the unit advances once per high-to-low change of its count pin. If the pin is first sampled low at clock edge k after being high, the increment lands at edge k+2. Each change gives exactly one increment.
- R4: In mode 00, bits 4:0 of the low byte act as a 5-bit prescaler and bits 7:5 hold their value. The high byte advances when the prescaler wraps. The counter overflows when both wrap together.
- R5: In mode 01, high:low counts as one 16-bit value and overflows when it wraps from FFFFh to 0000h.
- R6: In mode 10, only the low byte counts. When it overflows from FFh, it loads the high byte's value, and the high byte is left unchanged.
- R7: In mode 11 on timer 0, the low byte counts under timer 0's controls and sets flag 0 on wrap. The high byte counts internal ticks whenever timer 1's run input is high, and sets flag 1 on wrap. Timer 1 in mode 11 holds its count.
- R8: A bus write to a count byte replaces that byte in the same cycle, taking priority over any increment to it.
- R9: Flags are sticky, and `ovf` mirrors them. A write to address 5 loads bits 1:0 into the flags. That write takes priority over a wrap in the same cycle, and writing 0 clears a flag.
- R10: After reset, the mode register, all four count bytes and both flags are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| addr | input | 3 | Bus register address |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data for `addr` |
| runEn | input | 2 | Run enable per timer |
| intPin | input | 2 | Gate pin per timer |
| cntPin | input | 2 | External count pin per timer (asynchronous) |
| ovf | output | 2 | Sticky overflow flags |

## Verification
A wrong tick enable or a misdecoded mode shows up as a count byte that drifts from the expected value. That drift is visible on the next bus read of the affected byte, one cycle after the faulty edge. A mistake in wrap detection appears on `ovf` in the same cycle, and it stays there because the flags are sticky. A fault in the pin synchroniser moves the increment by one or more cycles, or doubles it, so a bench that compares the count in every cycle sees it at once.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int NIBBLE_W   = 4;
  localparam int MODE_W     = NUM_TIMERS * NIBBLE_W;
  localparam int PRESC_W    = 5;
  localparam int SYNC_DEPTH = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd5;

  typedef enum logic [1:0] {
    MODE_PRESC = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_RELD  = 2'b10,
    MODE_SPLIT = 2'b11
  } countMode_e;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] tick;
    logic                  splitTick;
    logic [NUM_TIMERS-1:0] wrLow;
    logic [NUM_TIMERS-1:0] wrHigh;
    logic                  wrFlag;
  } dtcStrobes_t;
endpackage

// File: rtl/dtc_pin_sync.sv
module dtc_pin_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] fallEdge
);
  logic [WIDTH-1:0] stage [DEPTH];
  logic [WIDTH-1:0] prevSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
      prevSample <= '0;
    end else begin
      stage[0] <= pinIn;
      for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
      prevSample <= stage[DEPTH-1];
    end
  end

  assign fallEdge = prevSample & ~stage[DEPTH-1];
endmodule

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [NUM_TIMERS-1:0] runEn,
  input  logic [NUM_TIMERS-1:0] intPin,
  input  logic [NUM_TIMERS-1:0] fallEdge,
  output logic [MODE_W-1:0]     modeReg,
  output dtcStrobes_t           strobes
);
  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (wrEn && addr == ADDR_MODE) modeReg <= wrData;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_unit
    logic       gateOn, ctSel, enabled, evt;
    countMode_e unitMode;
    assign gateOn   = modeReg[i*NIBBLE_W + 3];
    assign ctSel    = modeReg[i*NIBBLE_W + 2];
    assign unitMode = countMode_e'(modeReg[i*NIBBLE_W +: 2]);
    assign enabled  = runEn[i] & (~gateOn | intPin[i]);
    assign evt      = ctSel ? fallEdge[i] : 1'b1;
    if (i == 1) begin : g_hold
      assign strobes.tick[i] = enabled & evt & (unitMode != MODE_SPLIT);
    end else begin : g_free
      assign strobes.tick[i] = enabled & evt;
    end
    assign strobes.wrLow[i]  = wrEn && (addr == ADDR_W'(1 + 2*i));
    assign strobes.wrHigh[i] = wrEn && (addr == ADDR_W'(2 + 2*i));
  end

  assign strobes.splitTick = (countMode_e'(modeReg[1:0]) == MODE_SPLIT) & runEn[1];
  assign strobes.wrFlag    = wrEn && (addr == ADDR_FLAG);
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  dtcStrobes_t                        strobes,
  input  logic [MODE_W-1:0]                  modeReg,
  input  logic [BYTE_W-1:0]                  wrData,
  output logic [NUM_TIMERS-1:0][BYTE_W-1:0]  cntLow,
  output logic [NUM_TIMERS-1:0][BYTE_W-1:0]  cntHigh,
  output logic [NUM_TIMERS-1:0]              ovfFlag
);
  logic [NUM_TIMERS-1:0] wrapVec;
  logic                  splitWrap;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic [BYTE_W-1:0] lowQ, highQ, lowNext, highNext;
    logic              wrapNow;
    countMode_e        unitMode;
    assign unitMode = countMode_e'(modeReg[i*NIBBLE_W +: 2]);

    always_comb begin
      lowNext  = lowQ;
      highNext = highQ;
      wrapNow  = 1'b0;
      if (strobes.tick[i]) begin
        unique case (unitMode)
          MODE_PRESC: begin
            lowNext[PRESC_W-1:0] = lowQ[PRESC_W-1:0] + 1'b1;
            if (&lowQ[PRESC_W-1:0]) begin
              highNext = highQ + 1'b1;
              wrapNow  = &highQ;
            end
          end
          MODE_WIDE: begin
            {highNext, lowNext} = {highQ, lowQ} + 1'b1;
            wrapNow = &{highQ, lowQ};
          end
          MODE_RELD: begin
            if (&lowQ) begin
              lowNext = highQ;
              wrapNow = 1'b1;
            end else begin
              lowNext = lowQ + 1'b1;
            end
          end
          MODE_SPLIT: begin
            lowNext = lowQ + 1'b1;
            wrapNow = &lowQ;
          end
          default: ;
        endcase
      end
      if (i == 0 && strobes.splitTick) highNext = highQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowQ  <= '0;
        highQ <= '0;
      end else begin
        lowQ  <= strobes.wrLow[i]  ? wrData : lowNext;
        highQ <= strobes.wrHigh[i] ? wrData : highNext;
      end
    end

    assign cntLow[i]  = lowQ;
    assign cntHigh[i] = highQ;
    assign wrapVec[i] = wrapNow;
  end

  assign splitWrap = strobes.splitTick & (&cntHigh[0]);

  always_ff @(posedge clk) begin
    if (!rstN) ovfFlag <= '0;
    else if (strobes.wrFlag) ovfFlag <= wrData[NUM_TIMERS-1:0];
    else ovfFlag <= ovfFlag | wrapVec | {splitWrap, 1'b0};
  end
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import dtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wrData,
  output logic [BYTE_W-1:0]     rdData,
  input  logic [NUM_TIMERS-1:0] runEn,
  input  logic [NUM_TIMERS-1:0] intPin,
  input  logic [NUM_TIMERS-1:0] cntPin,
  output logic [NUM_TIMERS-1:0] ovf
);
  logic [NUM_TIMERS-1:0]             fallEdge;
  logic [MODE_W-1:0]                 modeReg;
  dtcStrobes_t                       strobes;
  logic [NUM_TIMERS-1:0][BYTE_W-1:0] cntLow, cntHigh;
  logic [NUM_TIMERS-1:0]             ovfFlag;

  dtc_pin_sync #(.WIDTH(NUM_TIMERS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(cntPin), .fallEdge(fallEdge)
  );

  dtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .runEn(runEn), .intPin(intPin), .fallEdge(fallEdge),
    .modeReg(modeReg), .strobes(strobes)
  );

  dtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeReg(modeReg),
    .wrData(wrData), .cntLow(cntLow), .cntHigh(cntHigh), .ovfFlag(ovfFlag)
  );

  always_comb begin
    unique case (addr)
      3'd0:    rdData = modeReg;
      3'd1:    rdData = cntLow[0];
      3'd2:    rdData = cntHigh[0];
      3'd3:    rdData = cntLow[1];
      3'd4:    rdData = cntHigh[1];
      3'd5:    rdData = {{(BYTE_W-NUM_TIMERS){1'b0}}, ovfFlag};
      default: rdData = '0;
    endcase
  end

  assign ovf = ovfFlag;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              wrEn,
  input logic [ADDR_W-1:0]                 addr,
  input logic [BYTE_W-1:0]                 wrData,
  input logic [NUM_TIMERS-1:0]             intPin,
  input logic [MODE_W-1:0]                 modeReg,
  input logic [NUM_TIMERS-1:0][BYTE_W-1:0] cntLow,
  input logic [NUM_TIMERS-1:0][BYTE_W-1:0] cntHigh,
  input logic [NUM_TIMERS-1:0]             ovfFlag
);
  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[3] && !intPin[0] && !(wrEn && addr == 3'd1)) |=> $stable(cntLow[0]));

  // R6
  reload_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b10 && !(wrEn && addr == 3'd2)) |=> $stable(cntHigh[0]));

  // R7
  split_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !(wrEn && (addr == 3'd3 || addr == 3'd4)))
      |=> ($stable(cntLow[1]) && $stable(cntHigh[1])));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1) |=> (cntLow[0] == $past(wrData)));

  // R9
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag[0] && !(wrEn && addr == 3'd5)) |=> ovfFlag[0]);

  // R9
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag[1] && !(wrEn && addr == 3'd5)) |=> ovfFlag[1]);
endmodule

bind dual_timer_counter dtc_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .intPin(intPin), .modeReg(modeReg), .cntLow(cntLow), .cntHigh(cntHigh),
  .ovfFlag(ovfFlag)
);

// File: tb/tb_dual_timer_counter.sv
module tb_dual_timer_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] runEn = '0, intPin = '0, cntPin = '0, ovf;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench reference state
  logic [7:0] mM;
  logic [7:0] lo [2];
  logic [7:0] hi [2];
  logic [1:0] fl, s1, s2, pv;

  dual_timer_counter dut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return mM;
      3'd1: return lo[0];
      3'd2: return hi[0];
      3'd3: return lo[1];
      3'd4: return hi[1];
      3'd5: return {6'b0, fl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic string addrTag(logic [2:0] a);
    if (a == 3'd1 || a == 3'd2) return modeTag(mM[1:0]);
    if (a == 3'd3 || a == 3'd4) return modeTag(mM[5:4]);
    if (a == 3'd5) return "R9";
    return "R1";
  endfunction

  task automatic modelReset();
    mM = '0; lo[0] = '0; lo[1] = '0; hi[0] = '0; hi[1] = '0;
    fl = '0; s1 = '0; s2 = '0; pv = '0;
  endtask

  task automatic modelStep();
    logic [1:0] fall, wrap;
    logic [7:0] nlo [2];
    logic [7:0] nhi [2];
    fall = pv & ~s2;
    pv = s2; s2 = s1; s1 = cntPin;
    wrap = '0;
    for (int i = 0; i < 2; i++) begin
      logic [1:0] md;
      logic tk;
      logic [15:0] w;
      md = mM[4*i +: 2];
      tk = runEn[i] && (!mM[4*i+3] || intPin[i]) && (mM[4*i+2] ? fall[i] : 1'b1);
      if (i == 1 && md == 2'b11) tk = 1'b0;
      nlo[i] = lo[i]; nhi[i] = hi[i];
      if (tk) begin
        if (md == 2'b00) begin
          nlo[i] = {lo[i][7:5], 5'(lo[i][4:0] + 5'd1)};
          if (lo[i][4:0] == 5'd31) begin
            nhi[i] = hi[i] + 8'd1;
            if (hi[i] == 8'hFF) wrap[i] = 1'b1;
          end
        end else if (md == 2'b01) begin
          w = {hi[i], lo[i]} + 16'd1;
          nhi[i] = w[15:8]; nlo[i] = w[7:0];
          if (w == 16'd0) wrap[i] = 1'b1;
        end else if (md == 2'b10) begin
          if (lo[i] == 8'hFF) begin nlo[i] = hi[i]; wrap[i] = 1'b1; end
          else nlo[i] = lo[i] + 8'd1;
        end else begin
          nlo[i] = lo[i] + 8'd1;
          if (lo[i] == 8'hFF) wrap[i] = 1'b1;
        end
      end
    end
    if (mM[1:0] == 2'b11 && runEn[1]) begin
      nhi[0] = hi[0] + 8'd1;
      if (hi[0] == 8'hFF) wrap[1] = 1'b1;
    end
    if (wrEn && addr == 3'd5) fl = wrData[1:0];
    else fl = fl | wrap;
    if (wrEn) begin
      case (addr)
        3'd0: mM = wrData;
        3'd1: nlo[0] = wrData;
        3'd2: nhi[0] = wrData;
        3'd3: nlo[1] = wrData;
        3'd4: nhi[1] = wrData;
        default: ;
      endcase
    end
    lo[0] = nlo[0]; lo[1] = nlo[1]; hi[0] = nhi[0]; hi[1] = nhi[1];
  endtask

  // advance one clock from a negedge; compare the probed register and flags
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(addrTag(addr), rdData, modelRead(addr));
    check("R9 ovf", {6'b0, ovf}, {6'b0, fl});
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state on every address
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      check("R10 reset", rdData, 8'h00);
    end
    check("R10 ovf", {6'b0, ovf}, 8'h00);

    // R6 / R9: reload mode wraps FE -> FF -> F0 and raises flag 0
    busWrite(3'd0, 8'h02);
    busWrite(3'd2, 8'hF0);
    busWrite(3'd1, 8'hFE);
    runEn = 2'b01; addr = 3'd1;
    tick(); check("R6 reload pre", rdData, 8'hFF);
    tick(); check("R6 reload", rdData, 8'hF0);
    check("R9 set", {6'b0, ovf}, 8'h01);

    // R8: write to a running byte wins over its increment
    busWrite(3'd1, 8'h33);
    check("R8 write wins", rdData, 8'h33);
    tick(); check("R8 resume", rdData, 8'h34);

    // R9: writing zero clears the flag
    busWrite(3'd5, 8'h00);
    check("R9 clear", {6'b0, ovf}, 8'h00);

    // R2: gated 16-bit mode only counts while the gate pin is high
    runEn = 2'b00;
    busWrite(3'd0, 8'h09);
    busWrite(3'd1, 8'h00);
    runEn = 2'b01; intPin = 2'b00; addr = 3'd1;
    repeat (4) tick();
    check("R2 gate low", rdData, 8'h00);
    intPin = 2'b01;
    repeat (3) tick();
    check("R2 gate high", rdData, 8'h03);

    // R3: counter select counts each falling edge of the pin once
    runEn = 2'b00; intPin = 2'b00;
    busWrite(3'd0, 8'h05);
    busWrite(3'd1, 8'h00);
    runEn = 2'b01; addr = 3'd1;
    for (int k = 0; k < 4; k++) begin
      cntPin = 2'b01; repeat (3) tick();
      cntPin = 2'b00; repeat (3) tick();
    end
    repeat (3) tick();
    check("R3 edge count", rdData, 8'h04);

    // R7: split mode, timer 0 high byte runs off timer 1's run input
    runEn = 2'b00;
    busWrite(3'd0, 8'h33);
    busWrite(3'd2, 8'hFE);
    busWrite(3'd1, 8'h10);
    busWrite(3'd3, 8'h77);
    runEn = 2'b10; addr = 3'd2;
    tick(); tick();
    check("R7 split high", rdData, 8'h00);
    check("R7 split flag", {6'b0, ovf}, 8'h02);
    addr = 3'd1; #1; check("R7 low held", rdData, 8'h10);
    addr = 3'd3; #1; check("R7 timer1 held", rdData, 8'h77);

    // R4: prescaler mode carries into the high byte every 32 ticks
    runEn = 2'b00;
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'hE0);
    busWrite(3'd2, 8'h00);
    runEn = 2'b01; addr = 3'd2;
    repeat (64) tick();
    check("R4 carry", rdData, 8'h02);
    addr = 3'd1; #1; check("R4 upper bits", rdData, 8'hE0);

    // R1..R9: random mix checked against the bench model every cycle
    for (int n = 0; n < 6000; n++) begin
      wrEn = ($urandom % 10) == 0;
      addr = 3'($urandom % 8);
      wrData = 8'($urandom);
      if (($urandom % 16) == 0) runEn = 2'($urandom);
      if (($urandom % 4) == 0) intPin = 2'($urandom);
      if (($urandom % 3) == 0) cntPin = 2'($urandom);
      tick();
    end

    finishRun();
  end
endmodule